// File: doc/BRIEF.md
# Snoop Address Range Filter

This block decides, for every bus request address that an external bus master presents, whether a cache snoop command should be issued. Software programs two registers. The first is a control word that selects a filter mode and a range size. The second is a base address. Each request address is compared with the base address, but only above a boundary set by the range size. The mode then decides the outcome. In one mode a hit enables the snoop. In another mode a hit suppresses it. The remaining modes keep the snoop output low.

A request is offered with a valid strobe, at most one per clock. The decision comes back with its own valid flag exactly one clock later. The range sizes do not follow one rule. The first four sizes grow by sixteen each step, from 4 KB through 64 KB and 1 MB to 16 MB. From there each size doubles, up to 256 MB.

Top module: `snoop_range_filter`

## Requirements
- R1: After reset, both registers read zero and `dec_valid` and `dec_snoop` are low. A zero control word means snooping is off with a 4 KB range.
- R2: When `reg_sel`=0, the control register is selected. Bits 1:0 hold the mode and bits 4:2 hold the range code, and both read back as written. Bits 31:5 read as zero, and writes to them are ignored.
- R3: When `reg_sel`=1, the base register is selected. It stores bits 31:12. Bits 11:0 read as zero whatever was written to them.
- R4: Range codes 0 to 3 compare address bits 31:12, 31:16, 31:20 and 31:24, which gives sizes of 4 KB, 64 KB, 1 MB and 16 MB.
- R5: Range codes 4 to 7 compare address bits 31:25, 31:26, 31:27 and 31:28, which gives sizes of 32 MB, 64 MB, 128 MB and 256 MB.
- R6: In mode 2 (binary 10), `dec_snoop` is 1 only when the request lies outside the selected range of the base.
- R7: In mode 3 (binary 11), `dec_snoop` is 1 only when the request lies inside the selected range of the base.
- R8: In mode 0 (off) and in mode 1 (prohibited), `dec_snoop` is 0 for every address and every range code.
- R9: A request that is accepted with `req_valid` produces `dec_valid`=1 and its `dec_snoop` on the next clock. Requests may follow each other on every cycle. `dec_valid` is 0 on the cycle after a cycle with no request, and `dec_snoop` is never 1 while `dec_valid` is 0.
- R10: A register write acts on requests that arrive on the following cycle. A request that arrives in the same cycle as a write is decided with the old register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control, 1 = base address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Request address |
| dec_valid | output | 1 | Decision valid, one clock after the request |
| dec_snoop | output | 1 | 1 = issue a snoop for that request |

## Verification
The assertions assume that `req_valid`, `req_addr`, `reg_we` and `reg_sel` are held stable and free of X across each rising edge, and that `reg_sel` is a known value whenever a write is made. The bench keeps to these assumptions. It changes every input only on the falling clock edge, and it leaves the registers alone while a request sweep is in progress. The one exception is the dedicated test of a write and a request in the same cycle. The sweep covers all four modes and all eight range codes. For each combination it offers back-to-back requests at the base itself, just inside the range boundary, just outside it, at the top of the range, and with the top address bit flipped.

// File: rtl/snf_pkg.sv
package snf_pkg;
   localparam int unsigned BASE_LSB = 12;   // finest granule: 4 KB
   localparam int unsigned TOP_LSB  = 28;   // coarsest granule: 256 MB

   typedef enum logic [1:0] {
      SNP_OFF  = 2'b00,
      SNP_RSVD = 2'b01,
      SNP_MISS = 2'b10,   // snoop when outside the window
      SNP_HIT  = 2'b11    // snoop when inside the window
   } snp_mode_e;

   // Lowest compared address bit for a range code (R4, R5)
   function automatic int unsigned range_lsb(input logic [2:0] code);
      if (code[2] == 1'b0) return BASE_LSB + 4 * int'(code);
      else                 return 21 + int'(code);
   endfunction
endpackage

// File: rtl/snf_regs.sv
module snf_regs
   import snf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rdata,
   output snp_mode_e         mode,
   output logic [2:0]        range_code,
   output logic [ADDR_W-1:0] base
);
   localparam int unsigned BASE_W = ADDR_W - BASE_LSB;
   localparam int unsigned RSVD_W = ADDR_W - 5;

   logic [1:0]        mode_q;
   logic [2:0]        range_q;
   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 2'b00;
         range_q <= 3'b000;
         base_q  <= '0;
      end else if (we) begin
         if (sel) base_q <= wdata[ADDR_W-1:BASE_LSB];
         else begin
            mode_q  <= wdata[1:0];
            range_q <= wdata[4:2];
         end
      end
   end

   assign mode       = snp_mode_e'(mode_q);
   assign range_code = range_q;
   assign base       = {base_q, {BASE_LSB{1'b0}}};
   assign rdata      = sel ? base : {{RSVD_W{1'b0}}, range_q, mode_q};

   AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !sel) |=> ({range_code, mode} == $past(wdata[4:0]))); // R2
   AST_BASE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel) |=> (base[ADDR_W-1:BASE_LSB] == $past(wdata[ADDR_W-1:BASE_LSB]))); // R3
   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(base) && $stable(mode) && $stable(range_code))); // R10
endmodule

// File: rtl/snf_mask_gen.sv
module snf_mask_gen
   import snf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [2:0]        range_code,
   output logic [ADDR_W-1:0] mask
);
   int unsigned lsb;
   always_comb lsb = range_lsb(range_code);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < BASE_LSB) begin : g_never
         assign mask[i] = 1'b0;
      end else if (i >= TOP_LSB) begin : g_always
         assign mask[i] = 1'b1;
      end else begin : g_sel
         assign mask[i] = (32'(i) >= lsb);
      end
   end
endmodule

// File: rtl/snf_decide.sv
module snf_decide
   import snf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   input  snp_mode_e         mode,
   output logic              dec_valid,
   output logic              dec_snoop
);
   logic in_window;
   logic snoop_d;

   assign in_window = (((req_addr ^ base) & mask) == '0);

   always_comb begin
      unique case (mode)
         SNP_MISS: snoop_d = !in_window;
         SNP_HIT:  snoop_d = in_window;
         default:  snoop_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_snoop <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         dec_snoop <= req_valid & snoop_d;
      end
   end

   AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid); // R9
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid); // R9
   AST_SNOOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      dec_snoop |-> dec_valid); // R9
   AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mode[1]) |=> !dec_snoop); // R8
   AST_HIT_FAR_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == SNP_HIT && req_addr[ADDR_W-1:TOP_LSB] != base[ADDR_W-1:TOP_LSB])
      |=> !dec_snoop); // R7
   AST_MISS_FAR_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == SNP_MISS && req_addr[ADDR_W-1:TOP_LSB] != base[ADDR_W-1:TOP_LSB])
      |=> dec_snoop); // R6
endmodule

// File: rtl/snoop_range_filter.sv
module snoop_range_filter
   import snf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              dec_valid,
   output logic              dec_snoop
);
   if (ADDR_W <= TOP_LSB) begin : g_bad_width
      $error("snoop_range_filter: ADDR_W must exceed the coarsest range boundary");
   end

   snp_mode_e         mode;
   logic [2:0]        range_code;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] mask;

   snf_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .mode(mode), .range_code(range_code), .base(base)
   );

   snf_mask_gen #(.ADDR_W(ADDR_W)) u_mask (
      .range_code(range_code), .mask(mask)
   );

   snf_decide #(.ADDR_W(ADDR_W)) u_decide (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .base(base), .mask(mask), .mode(mode),
      .dec_valid(dec_valid), .dec_snoop(dec_snoop)
   );
endmodule

// File: tb/snoop_range_filter_bench.sv
module snoop_range_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        dec_valid;
   logic        dec_snoop;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   snoop_range_filter u_snoop_range_filter (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_addr(req_addr),
      .dec_valid(dec_valid), .dec_snoop(dec_snoop)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sel, input string tag, input logic [31:0] exp);
      @(negedge clk);
      reg_sel = sel;
      #1 check(tag, reg_rdata, exp);
   endtask

   function automatic int unsigned lsb_of(input int code);
      return (code < 4) ? 12 + 4 * code : 21 + code;
   endfunction

   function automatic logic exp_snoop(input int mode, input int code,
                                      input logic [31:0] base, input logic [31:0] a);
      logic [31:0] m;
      logic hit;
      m   = 32'hFFFF_FFFF << lsb_of(code);
      hit = ((a & m) == (base & m));
      if (mode == 2) return !hit;   // R6
      if (mode == 3) return hit;    // R7
      return 1'b0;                  // R8
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] bases [3];
      logic [31:0] a;
      string tag;
      bases[0] = 32'hA5A5_A000;
      bases[1] = 32'h0000_0000;
      bases[2] = 32'h7FFF_F000;

      // R1: reset state
      #1;
      check("R1 dec_valid", {31'b0, dec_valid}, 32'd0);
      check("R1 dec_snoop", {31'b0, dec_snoop}, 32'd0);
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      rd(1'b0, "R1 ctrl", 32'h0);
      rd(1'b1, "R1 base", 32'h0);

      // R2: control fields and reserved bits
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, "R2 all ones", 32'h0000_001F);
      wr(1'b0, 32'h1234_5609);
      rd(1'b0, "R2 pattern", 32'h0000_0009);
      // R3: base keeps 31:12 only
      wr(1'b1, 32'hDEAD_BEEF);
      rd(1'b1, "R3 base", 32'hDEAD_B000);

      // R4 R5 R6 R7 R8 R9: sweep with back-to-back requests
      foreach (bases[b]) begin
         wr(1'b1, bases[b]);
         for (int mode = 0; mode < 4; mode++) begin
            for (int code = 0; code < 8; code++) begin
               wr(1'b0, 32'(code * 4 + mode));
               for (int k = 0; k < 5; k++) begin
                  int unsigned l;
                  l = lsb_of(code);
                  case (k)
                     0: a = bases[b] | 32'h0000_0ABC;
                     1: a = bases[b] ^ (32'h1 << (l - 1));
                     2: a = bases[b] ^ (32'h1 << l);
                     3: a = bases[b] | ~(32'hFFFF_FFFF << l);
                     default: a = bases[b] ^ 32'h8000_0000;
                  endcase
                  @(negedge clk);
                  req_valid = 1'b1; req_addr = a;
                  @(posedge clk);
                  #1;
                  tag = $sformatf("%s %s R9 mode=%0d code=%0d addr=%h",
                        (mode == 2) ? "R6" : (mode == 3) ? "R7" : "R8",
                        (code < 4) ? "R4" : "R5", mode, code, a);
                  check(tag, {31'b0, dec_valid}, 32'd1);
                  check(tag, {31'b0, dec_snoop},
                        {31'b0, exp_snoop(mode, code, bases[b], a)});
               end
               @(negedge clk) req_valid = 1'b0;
               @(posedge clk) #1;
               check("R9 idle valid", {31'b0, dec_valid}, 32'd0);
               check("R9 idle snoop", {31'b0, dec_snoop}, 32'd0);
            end
         end
      end

      // R10: a write in the same cycle as a request does not affect that request
      wr(1'b1, 32'h4000_0000);
      wr(1'b0, 32'h0000_0003);             // inside-window mode, 4 KB
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h4000_0123;
      reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0002;
      @(posedge clk) #1;
      check("R10 same cycle old mode", {31'b0, dec_snoop}, 32'd1);
      @(negedge clk) reg_we = 1'b0;
      @(posedge clk) #1;
      check("R10 next cycle new mode", {31'b0, dec_snoop}, 32'd0);
      @(negedge clk) req_valid = 1'b0;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule